// File: doc/BRIEF.md
# Indexed Memory Operand Fetch Sequencer

This block is the control sequencer that fetches the memory operand of an accumulator arithmetic or logic instruction. A pulse on `start_i` while the block is idle makes it read the next instruction byte at the program counter. If that byte is an index prefix, the block then reads the opcode and a signed displacement. Next it spends one internal machine cycle adding the displacement to the chosen index register, and finally it reads the operand at the resulting address. If the first byte is not a prefix, it is the opcode itself, and the operand is read straight away at the address held in a 16-bit pointer register.

The block drives a plain read-only memory interface made of an address, a read strobe and a data input. The memory answers in the same cycle, with no wait states. The block reports its position in the schedule as a machine-cycle number and a clock-state number. When the operand has been captured, it raises a one-clock `done_o` pulse and presents the operand byte and the 3-bit operation select to the ALU. The ALU is a separate block.

Top module: `opfetch_seq`

## Requirements
- R1: While and after reset, until the first start, `m_cycle_o` and `t_state_o` are 0, `mem_rd_o` and `done_o` are 0, and `pc_o` equals the `RESET_PC` parameter (default 0).
- R2: A start sampled while idle makes the next clock the first clock of machine cycle 1. In that clock `mem_rd_o` is 1 and `mem_addr_o` equals `pc_o`. The first byte is an index prefix when (byte AND 0xDF) equals 0xDD. Bit 5 of the prefix selects the index register: 0 selects `idx0_i` (0xDD) and 1 selects `idx1_i` (0xFD).
- R3: A first byte that is not a prefix is the opcode. The operand is then read at `ptr_i` in machine cycle 2, and no displacement is fetched. The whole instruction takes 4+3 = 7 clocks, and `done_o` is high in the 8th clock after the start edge.
- R4: After a prefix, the schedule is 4, 4, 3, 5 and 3 clocks (19 in total). Machine cycles 1, 2 and 3 read the prefix, the opcode and the displacement at consecutive program-counter addresses, machine cycle 5 reads the operand, and `done_o` is high in the 20th clock after the start edge.
- R5: In indexed mode the operand address is the selected index register plus the displacement sign-extended to 16 bits, wrapped modulo 65536.
- R6: Machine cycle 4 of the indexed form is internal: `mem_rd_o` stays 0 in all 5 of its clocks.
- R7: `done_o` lasts exactly one clock. In that clock, `op_data_o` holds the byte that was on `mem_din_i` in the last clock of the operand read, and `op_sel_o` holds bits 5:3 of the opcode byte.
- R8: `pc_o` rises by one for each prefix, opcode or displacement byte fetched, and never for the operand read. That is +1 per register-indirect instruction and +3 per indexed instruction.
- R9: A start that arrives while an instruction is in progress is ignored. The schedule continues unchanged and exactly one `done_o` pulse results.
- R10: `t_state_o` counts 1, 2, … up to the length of the current machine cycle, and `m_cycle_o` numbers the cycle from 1. Both are 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin one instruction (sampled when idle) |
| ptr_i | input | 16 | Pointer register for register-indirect operands |
| idx0_i | input | 16 | First index register |
| idx1_i | input | 16 | Second index register |
| mem_addr_o | output | 16 | Memory read address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_din_i | input | 8 | Memory read data |
| pc_o | output | 16 | Program counter |
| m_cycle_o | output | 3 | Current machine cycle number, 0 when idle |
| t_state_o | output | 3 | Current clock state within the machine cycle, 0 when idle |
| done_o | output | 1 | One-clock operand-delivered pulse |
| op_data_o | output | 8 | Operand byte for the ALU |
| op_sel_o | output | 3 | Operation select for the ALU |

## Verification
Counting from the clock edge that samples `start_i`, the k-th schedule clock is visible right after edge k. The done pulse is due exactly 8 clocks after that edge for the register-indirect form and 20 clocks after it for the indexed form. The bench expects the machine-cycle number, the clock-state number, the strobe and the address on every schedule clock, and it samples them on the falling edge that follows each rising edge. Each start pushes the expected operand, select, program counter and due cycle into a queue. A monitor pops one entry per done pulse and compares the cycle number as well as the data, so an early, late, missing or extra pulse is reported.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;

  localparam int MC_W = 3;
  localparam int TS_W = 3;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FETCH = 3'd1,
    PH_OPC   = 3'd2,
    PH_DISP  = 3'd3,
    PH_ADD   = 3'd4,
    PH_READ  = 3'd5
  } phase_e;

  localparam logic [7:0] PFX_MASK    = 8'hDF;
  localparam logic [7:0] PFX_MATCH   = 8'hDD;
  localparam int         PFX_SEL_BIT = 5;
  localparam int         SEL_LO      = 3;
  localparam int         SEL_W       = 3;

  localparam int LEN_FETCH = 4;
  localparam int LEN_OPC   = 4;
  localparam int LEN_DISP  = 3;
  localparam int LEN_ADD   = 5;
  localparam int LEN_READ  = 3;

  function automatic logic [TS_W-1:0] phase_len(input phase_e ph);
    logic [TS_W-1:0] len;
    case (ph)
      PH_FETCH: len = TS_W'(LEN_FETCH);
      PH_OPC:   len = TS_W'(LEN_OPC);
      PH_DISP:  len = TS_W'(LEN_DISP);
      PH_ADD:   len = TS_W'(LEN_ADD);
      PH_READ:  len = TS_W'(LEN_READ);
      default:  len = '0;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/opfetch_rst_sync.sv
module opfetch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/opfetch_tstate.sv
module opfetch_tstate #(
  parameter int TS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            begin_i,
  input  logic [TS_W-1:0] len_i,
  output logic [TS_W-1:0] t_o,
  output logic            last_o
);

  logic [TS_W-1:0] t_q;
  logic [TS_W-1:0] t_d;
  logic            t_en;

  assign last_o = (t_q != '0) && (t_q == len_i);
  assign t_en   = begin_i || (t_q != '0);

  always_comb begin
    if (begin_i) begin
      t_d = TS_W'(1);
    end else if (last_o) begin
      t_d = '0;
    end else begin
      t_d = t_q + TS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
    end else if (t_en) begin
      t_q <= t_d;
    end
  end

  assign t_o = t_q;

endmodule

// File: rtl/opfetch_prefix_dec.sv
module opfetch_prefix_dec
  import opfetch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic              is_prefix_o,
  output logic              idx_sel_o
);

  assign is_prefix_o = ((byte_i & DATA_W'(PFX_MASK)) == DATA_W'(PFX_MATCH));
  assign idx_sel_o   = byte_i[PFX_SEL_BIT];

endmodule

// File: rtl/opfetch_ea.sv
module opfetch_ea #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] idx0_i,
  input  logic [ADDR_W-1:0] idx1_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] disp_i,
  output logic [ADDR_W-1:0] ea_o
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] disp_ext;

  assign base = sel_i ? idx1_i : idx0_i;

  generate
    if (ADDR_W > DATA_W) begin : g_sext
      assign disp_ext = {{(ADDR_W-DATA_W){disp_i[DATA_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[ADDR_W-1:0];
    end
  endgenerate

  assign ea_o = base + disp_ext;

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
  import opfetch_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          SYNC_STG = 2,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [ADDR_W-1:0] idx0_i,
  input  logic [ADDR_W-1:0] idx1_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [DATA_W-1:0] mem_din_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [MC_W-1:0]   m_cycle_o,
  output logic [TS_W-1:0]   t_state_o,
  output logic              done_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [SEL_W-1:0]  op_sel_o
);

  logic rst_core_n;

  phase_e            phase_q, phase_d;
  logic [MC_W-1:0]   mc_q, mc_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] ea_q, ea_d;
  logic [DATA_W-1:0] disp_q, disp_d;
  logic              sel_q, sel_d;
  logic [SEL_W-1:0]  opsel_q, opsel_d;
  logic [DATA_W-1:0] opdat_q, opdat_d;
  logic              done_q, done_d;

  logic              t_last;
  logic              t_begin;
  logic [TS_W-1:0]   t_len;
  logic [TS_W-1:0]   t_now;
  logic              pfx_hit;
  logic              pfx_sel;
  logic [ADDR_W-1:0] ea_sum;
  logic              ctl_en;

  opfetch_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign t_len = phase_len(phase_q);

  opfetch_tstate #(.TS_W(TS_W)) u_tstate (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .begin_i (t_begin),
    .len_i   (t_len),
    .t_o     (t_now),
    .last_o  (t_last)
  );

  opfetch_prefix_dec #(.DATA_W(DATA_W)) u_pfx (
    .byte_i      (mem_din_i),
    .is_prefix_o (pfx_hit),
    .idx_sel_o   (pfx_sel)
  );

  opfetch_ea #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ea (
    .idx0_i (idx0_i),
    .idx1_i (idx1_i),
    .sel_i  (sel_q),
    .disp_i (disp_q),
    .ea_o   (ea_sum)
  );

  // Next-state logic: all decisions are taken on the last clock of a cycle.
  always_comb begin
    phase_d = phase_q;
    mc_d    = mc_q;
    pc_d    = pc_q;
    ea_d    = ea_q;
    disp_d  = disp_q;
    sel_d   = sel_q;
    opsel_d = opsel_q;
    opdat_d = opdat_q;
    done_d  = 1'b0;

    if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_d = PH_FETCH;
        mc_d    = MC_W'(1);
      end
    end else if (t_last) begin
      mc_d = mc_q + MC_W'(1);
      case (phase_q)
        PH_FETCH: begin
          pc_d = pc_q + ADDR_W'(1);
          if (pfx_hit) begin
            sel_d   = pfx_sel;
            phase_d = PH_OPC;
          end else begin
            opsel_d = mem_din_i[SEL_LO +: SEL_W];
            ea_d    = ptr_i;
            phase_d = PH_READ;
          end
        end
        PH_OPC: begin
          pc_d    = pc_q + ADDR_W'(1);
          opsel_d = mem_din_i[SEL_LO +: SEL_W];
          phase_d = PH_DISP;
        end
        PH_DISP: begin
          pc_d    = pc_q + ADDR_W'(1);
          disp_d  = mem_din_i;
          phase_d = PH_ADD;
        end
        PH_ADD: begin
          ea_d    = ea_sum;
          phase_d = PH_READ;
        end
        PH_READ: begin
          opdat_d = mem_din_i;
          done_d  = 1'b1;
          mc_d    = '0;
          phase_d = PH_IDLE;
        end
        default: begin
          mc_d    = '0;
          phase_d = PH_IDLE;
        end
      endcase
    end
  end

  assign t_begin = ((phase_q == PH_IDLE) && start_i) ||
                   (t_last && (phase_d != PH_IDLE));
  assign ctl_en  = (phase_q == PH_IDLE) ? start_i : t_last;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      phase_q <= PH_IDLE;
      mc_q    <= '0;
      pc_q    <= ADDR_W'(RESET_PC);
      ea_q    <= '0;
      disp_q  <= '0;
      sel_q   <= 1'b0;
      opsel_q <= '0;
      opdat_q <= '0;
    end else if (ctl_en) begin
      phase_q <= phase_d;
      mc_q    <= mc_d;
      pc_q    <= pc_d;
      ea_q    <= ea_d;
      disp_q  <= disp_d;
      sel_q   <= sel_d;
      opsel_q <= opsel_d;
      opdat_q <= opdat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign mem_rd_o   = (phase_q == PH_FETCH) || (phase_q == PH_OPC) ||
                      (phase_q == PH_DISP)  || (phase_q == PH_READ);
  assign mem_addr_o = (phase_q == PH_READ) ? ea_q : pc_q;
  assign pc_o       = pc_q;
  assign m_cycle_o  = mc_q;
  assign t_state_o  = t_now;
  assign done_o     = done_q;
  assign op_data_o  = opdat_q;
  assign op_sel_o   = opsel_q;

endmodule

// File: rtl/opfetch_seq_chk.sv
module opfetch_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int MC_W   = 3,
  parameter int TS_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [MC_W-1:0]   m_cycle_o,
  input logic [TS_W-1:0]   t_state_o,
  input logic              done_o
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cycle_o == '0) |-> (!mem_rd_o && t_state_o == '0)); // R10

  AST_TSTATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (t_state_o > TS_W'(1)) |-> ($past(t_state_o) == t_state_o - TS_W'(1))); // R10

  AST_TSTATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (t_state_o <= TS_W'(5))); // R10

  AST_ADD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cycle_o == MC_W'(4)) |-> !mem_rd_o); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(mem_rd_o) && $past(t_state_o) == TS_W'(3))); // R7

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_o != $past(pc_o)) |-> (pc_o == $past(pc_o) + ADDR_W'(1))); // R8

endmodule

bind opfetch_seq opfetch_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rd_o  (mem_rd_o),
  .pc_o      (pc_o),
  .m_cycle_o (m_cycle_o),
  .t_state_o (t_state_o),
  .done_o    (done_o)
);

// File: tb/opfetch_seq_tb_top.sv
`timescale 1ns/1ps
module opfetch_seq_tb_top;

  typedef struct {
    logic [7:0]  data;
    logic [2:0]  sel;
    logic [15:0] pc;
    int          cyc;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ptr = 16'h0;
  logic [15:0] idx0 = 16'h0;
  logic [15:0] idx1 = 16'h0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_din;
  logic [15:0] pc;
  logic [2:0]  m_cycle;
  logic [2:0]  t_state;
  logic        done;
  logic [7:0]  op_data;
  logic [2:0]  op_sel;

  logic [7:0]  mem [0:65535];
  exp_t        sb_q[$];
  int          cyc = 0;
  int          n_checks = 0;
  int          n_fail = 0;
  logic [15:0] pc_model = 16'h0000;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mem_din = mem_rd ? mem[mem_addr] : 8'h00;

  opfetch_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .ptr_i      (ptr),
    .idx0_i     (idx0),
    .idx1_i     (idx1),
    .mem_addr_o (mem_addr),
    .mem_rd_o   (mem_rd),
    .mem_din_i  (mem_din),
    .pc_o       (pc),
    .m_cycle_o  (m_cycle),
    .t_state_o  (t_state),
    .done_o     (done),
    .op_data_o  (op_data),
    .op_sel_o   (op_sel)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: call at a falling edge with the block idle.
  task automatic run_instr(input bit indexed, input logic [7:0] pfx,
                           input logic [7:0] opc, input logic [7:0] d,
                           input logic [7:0] operand, input int poke);
    logic [15:0] p;
    logic [15:0] ea;
    int          lens[5];
    int          ncyc;
    int          n;
    int          m;
    int          t;
    exp_t        e;
    p = pc_model;
    if (indexed) begin
      mem[p] = pfx;
      mem[p + 16'd1] = opc;
      mem[p + 16'd2] = d;
      ea = (pfx[5] ? idx1 : idx0) + {{8{d[7]}}, d};
      lens = '{4, 4, 3, 5, 3};
      ncyc = 5;
      n = 19;
      pc_model = p + 16'd3;
    end else begin
      mem[p] = opc;
      ea = ptr;
      lens = '{4, 3, 0, 0, 0};
      ncyc = 2;
      n = 7;
      pc_model = p + 16'd1;
    end
    mem[ea] = operand;
    e.data = operand;
    e.sel  = opc[5:3];
    e.pc   = pc_model;
    e.cyc  = cyc + 1 + n;
    e.tag  = indexed ? "R4" : "R3";
    sb_q.push_back(e);
    start = 1'b1;
    m = 1;
    t = 1;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      start = (j == poke);
      chk("R10", "m_cycle", m_cycle, m);
      chk("R10", "t_state", t_state, t);
      if (indexed && m == 4) begin
        chk("R6", "strobe in internal cycle", mem_rd, 0);
      end else begin
        chk("R2", "read strobe", mem_rd, 1);
        if (m == ncyc)
          chk(indexed ? "R5" : "R3", "operand address", mem_addr, ea);
        else
          chk(indexed ? "R4" : "R2", "fetch address", mem_addr, p + 16'(m - 1));
      end
      if (t == lens[m-1]) begin
        m++;
        t = 1;
      end else begin
        t++;
      end
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: one scoreboard entry per done pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb_q.size() == 0) begin
          chk("R9", "unexpected done pulse", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(e.tag, "done cycle", cyc, e.cyc);
          chk("R7", "operand", op_data, e.data);
          chk("R7", "operation select", op_sel, e.sel);
          chk("R8", "program counter", pc, e.pc);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 65536; a++) mem[a] = 8'h00;
    repeat (4) @(negedge clk);
    chk("R1", "done in reset", done, 0);
    chk("R1", "strobe in reset", mem_rd, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "m_cycle idle", m_cycle, 0);
    chk("R1", "t_state idle", t_state, 0);
    chk("R1", "strobe idle", mem_rd, 0);
    chk("R1", "done idle", done, 0);
    chk("R1", "pc reset", pc, 16'h0000);

    ptr = 16'h4000;
    run_instr(1'b0, 8'h00, 8'h96, 8'h00, 8'h5A, 0);              // R3
    idx0 = 16'h8000;
    run_instr(1'b1, 8'hDD, 8'h9E, 8'h05, 8'hC3, 0);              // R2 R4 R5 first index
    idx1 = 16'h9000;
    run_instr(1'b1, 8'hFD, 8'hA6, 8'h80, 8'h11, 0);              // R5 negative disp, second index
    idx1 = 16'hFFF8;
    run_instr(1'b1, 8'hFD, 8'hB6, 8'h7F, 8'hE7, 0);              // R5 wrap upward
    idx0 = 16'h0005;
    run_instr(1'b1, 8'hDD, 8'h86, 8'hF0, 8'h3C, 0);              // R5 wrap downward
    ptr = 16'h6001;
    run_instr(1'b0, 8'h00, 8'hED, 8'h00, 8'h77, 0);              // R2 near-prefix byte is opcode
    idx0 = 16'h8000;
    run_instr(1'b1, 8'hDD, 8'hBE, 8'h01, 8'h99, 10);             // R9 start during indexed
    ptr = 16'h4100;
    run_instr(1'b0, 8'h00, 8'h96, 8'h00, 8'h42, 3);              // R9 start during indirect

    repeat (25) @(negedge clk);
    chk("R9", "no extra instruction started", m_cycle, 0);
    chk("R8", "final program counter", pc, pc_model);
    chk("R9", "scoreboard drained", sb_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule